// File: doc/BRIEF.md
# Stack-Top Register Cache

This block replaces a visible register file with a 64-entry window of 32-bit words that mirrors the top of the program stack. The stack grows toward lower byte addresses. Software never names a register; it names a word offset from the stack pointer. Offset 0 is the word at the stack pointer, and offset k is the word at byte address `sp + 4*k`. The block keeps the stack pointer and a resident count. The resident window covers the addresses `sp` up to `sp + 4*(count-1)`. Each resident word is the live copy of that memory address.

Three frame operations move the window. Allocation lowers the stack pointer by a frame of n words. If the window would then hold more than 64 words, the block first writes the deepest resident words back to memory. Deallocation raises the stack pointer and releases words. Restore reloads words from memory, starting from the new top, until a requested number of them is resident. Spills and fills travel one word at a time over a valid/ready request port, with a separate response strobe for read data. While that traffic runs, the block holds `busy` and refuses new work. Offset 0 also acts as the accumulator: it has its own write port and its own read-out.

Top module: `stack_top_cache`

## Requirements
- R1: After reset the stack pointer equals the `RESET_SP` parameter, the resident count is 0, `busy` is low and no memory request is raised.
- R2: A write to offset k that lies inside the window (k < count) stores the word at address `sp + 4*k`. A later read at offset k returns that word as long as the address stays resident.
- R3: `accessErr` is high in the same cycle as any of these: a read with offset >= count, a write with offset >= count, or an accumulator write while count is 0. Such a write leaves the stored contents unchanged.
- R4: An allocation of n words (opKind 1) that fits (count + n <= 64) lowers `sp` by 4*n and raises count by n, one cycle after acceptance, with no memory traffic. Words already resident keep their addresses, so they appear at offsets raised by n.
- R5: An allocation for which count + n > 64 first spills count + n - 64 words as memory writes. The deepest word goes first, at address `sp + 4*(count-1)`, and each accepted write lowers count by one. After the spills the block applies the allocation, so count ends at 64. The count never exceeds 64.
- R6: A deallocation of n words (opKind 2) raises `sp` by 4*n one cycle after acceptance and sets count to max(0, count - n).
- R7: A restore of n words (opKind 3) with count < n issues memory reads at `sp + 4*count`, nearest the top first. Each response is stored and raises count by one, until count equals n. When count >= n already, a restore causes no traffic.
- R8: `busy` is high while spills or fills are in progress. Operations, offset writes and accumulator writes presented while `busy` is high are ignored.
- R9: `accOut` shows the word at offset 0. An accumulator write stores at offset 0 and takes priority over an offset write to offset 0 in the same cycle.
- R10: A memory request that has not been accepted keeps its valid, direction, address and write data unchanged until `memReqReady` is seen.
- R11: An operation count above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Frame operation request, taken when busy is low |
| opKind | input | 2 | 1 allocate, 2 deallocate, 3 restore, 0 none |
| opCount | input | 8 | Frame size in words, clipped to 64 |
| busy | output | 1 | Spill or fill in progress |
| rdEn | input | 1 | Offset read qualifier (used for the error flag) |
| rdOffset | input | 6 | Read word offset from the stack pointer |
| rdData | output | 32 | Word at rdOffset |
| wrEn | input | 1 | Offset write enable |
| wrOffset | input | 6 | Write word offset |
| wrData | input | 32 | Write data |
| accWe | input | 1 | Accumulator write enable |
| accData | input | 32 | Accumulator write data |
| accOut | output | 32 | Word at offset 0 |
| accessErr | output | 1 | Access outside the resident window |
| sp | output | 32 | Stack pointer (byte address) |
| residentCount | output | 7 | Number of resident words |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 spill write, 0 fill read |
| memReqAddr | output | 32 | Memory byte address |
| memReqWdata | output | 32 | Spill data |
| memRspValid | input | 1 | Fill data valid |
| memRspData | input | 32 | Fill data |

## Verification
The bench uses the default parameters: 64 entries, 32-bit words and addresses, and a reset stack pointer of 0x8000. Frames of at most 64 words can therefore fill the window from empty in one step, or push a full window into a spill of every entry. Because the window is small, random sequences of allocate, deallocate and restore keep wrapping the circular index past its end. They also return to previously spilled words, so fills read back data that the block itself wrote out. A random accept rate on the memory port exercises held requests.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_ALLOC   = 2'd1,
    OP_FREE    = 2'd2,
    OP_RESTORE = 2'd3
  } frameOp_e;

  typedef struct packed {
    logic growFrame;
    logic shrinkFrame;
    logic dropDeepest;
    logic loadFill;
  } ctrlStrobe_t;
endpackage

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH = 64,
  parameter logic [ADDR_W-1:0] RESET_SP = '0,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CNT_W-1:0]  amount,
  input  logic              userWe,
  input  logic [IDX_W-1:0]  userOff,
  input  logic [DATA_W-1:0] userData,
  input  logic              accWe,
  input  logic [DATA_W-1:0] accData,
  input  logic [IDX_W-1:0]  rdOffset,
  input  logic [DATA_W-1:0] fillData,
  output logic [ADDR_W-1:0] spOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] accOut,
  output logic [ADDR_W-1:0] spillAddr,
  output logic [DATA_W-1:0] spillData,
  output logic [ADDR_W-1:0] fillAddr
);
  logic [DATA_W-1:0] slots [DEPTH];
  logic [ADDR_W-1:0] spReg;
  logic [CNT_W-1:0]  cntReg;
  logic [IDX_W-1:0]  topIdx, spillIdx, fillIdx;
  logic [CNT_W-1:0]  deepOff;
  logic [ADDR_W-1:0] amountBytes;

  // circular placement: word address modulo the depth (depth is a power of two)
  assign topIdx      = spReg[IDX_W+1:2];
  assign deepOff     = cntReg - CNT_W'(1);
  assign spillIdx    = topIdx + deepOff[IDX_W-1:0];
  assign fillIdx     = topIdx + cntReg[IDX_W-1:0];
  assign amountBytes = ADDR_W'(amount) << 2;

  assign spillAddr = spReg + (ADDR_W'(deepOff) << 2);
  assign fillAddr  = spReg + (ADDR_W'(cntReg) << 2);
  assign spillData = slots[spillIdx];
  assign rdData    = slots[topIdx + rdOffset];
  assign accOut    = slots[topIdx];
  assign spOut     = spReg;
  assign cntOut    = cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg  <= RESET_SP;
      cntReg <= '0;
    end else if (strobe.growFrame) begin
      spReg  <= spReg - amountBytes;
      cntReg <= cntReg + amount;
    end else if (strobe.shrinkFrame) begin
      spReg  <= spReg + amountBytes;
      cntReg <= (amount >= cntReg) ? '0 : cntReg - amount;
    end else if (strobe.dropDeepest) begin
      cntReg <= cntReg - CNT_W'(1);
    end else if (strobe.loadFill) begin
      cntReg <= cntReg + CNT_W'(1);
    end
  end

  // storage carries no reset; later writes in this block win
  always_ff @(posedge clk) begin
    if (userWe) slots[topIdx + userOff] <= userData;
    if (accWe) slots[topIdx] <= accData;
    if (strobe.loadFill) slots[fillIdx] <= fillData;
  end
endmodule

// File: rtl/stc_control.sv
module stc_control
  import stc_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int OPC_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opKind,
  input  logic [OPC_W-1:0] opCount,
  input  logic [CNT_W-1:0] cnt,
  input  logic             memReqReady,
  input  logic             memRspValid,
  output ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] amount,
  output logic             busy,
  output logic             memReqValid,
  output logic             memReqWrite
);
  typedef enum logic [1:0] {S_IDLE, S_SPILL, S_FILL_REQ, S_FILL_WAIT} state_e;

  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(DEPTH);

  state_e           state, nxtState;
  logic [CNT_W-1:0] pendN;
  logic [CNT_W-1:0] clipN;
  logic [CNT_W:0]   reqSum, pendSum, fillNext;
  frameOp_e         kind;

  assign kind     = frameOp_e'(opKind);
  assign clipN    = (opCount > OPC_W'(DEPTH)) ? CNT_W'(DEPTH) : opCount[CNT_W-1:0];
  assign reqSum   = {1'b0, cnt} + {1'b0, clipN};
  assign pendSum  = {1'b0, cnt} + {1'b0, pendN};
  assign fillNext = {1'b0, cnt} + (CNT_W+1)'(1);
  assign busy     = (state != S_IDLE);

  always_comb begin
    nxtState    = state;
    strobe      = '0;
    amount      = clipN;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (state)
      S_IDLE: if (opValid) begin
        unique case (kind)
          OP_ALLOC:   if (reqSum > LIMIT) nxtState = S_SPILL;
                      else strobe.growFrame = 1'b1;
          OP_FREE:    strobe.shrinkFrame = 1'b1;
          OP_RESTORE: if (cnt < clipN) nxtState = S_FILL_REQ;
          default: ;
        endcase
      end
      S_SPILL: begin
        if (pendSum <= LIMIT) begin
          strobe.growFrame = 1'b1;
          amount = pendN;
          nxtState = S_IDLE;
        end else begin
          memReqValid = 1'b1;
          memReqWrite = 1'b1;
          strobe.dropDeepest = memReqReady;
        end
      end
      S_FILL_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nxtState = S_FILL_WAIT;
      end
      S_FILL_WAIT: if (memRspValid) begin
        strobe.loadFill = 1'b1;
        nxtState = (fillNext >= {1'b0, pendN}) ? S_IDLE : S_FILL_REQ;
      end
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      pendN <= '0;
    end else begin
      state <= nxtState;
      if (state == S_IDLE && opValid) pendN <= clipN;
    end
  end
endmodule

// File: rtl/stack_top_cache.sv
module stack_top_cache
  import stc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH = 64,
  parameter logic [ADDR_W-1:0] RESET_SP = 32'h0000_8000,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int OPC_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [OPC_W-1:0]  opCount,
  output logic              busy,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdOffset,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrOffset,
  input  logic [DATA_W-1:0] wrData,
  input  logic              accWe,
  input  logic [DATA_W-1:0] accData,
  output logic [DATA_W-1:0] accOut,
  output logic              accessErr,
  output logic [ADDR_W-1:0] sp,
  output logic [CNT_W-1:0]  residentCount,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);
  ctrlStrobe_t       strobe;
  logic [CNT_W-1:0]  amount;
  logic [ADDR_W-1:0] spillAddr, fillAddr;
  logic              rdOut, wrOut, accOutOfRange, userWe, accGo;

  assign rdOut         = rdEn && ({1'b0, rdOffset} >= residentCount);
  assign wrOut         = wrEn && ({1'b0, wrOffset} >= residentCount);
  assign accOutOfRange = accWe && (residentCount == '0);
  assign accessErr     = rdOut || wrOut || accOutOfRange;
  assign userWe        = wrEn && !wrOut && !busy;
  assign accGo         = accWe && !accOutOfRange && !busy;
  assign memReqAddr    = memReqWrite ? spillAddr : fillAddr;

  stc_control #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opCount(opCount),
    .cnt(residentCount), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strobe(strobe), .amount(amount), .busy(busy),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite)
  );

  stc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_SP(RESET_SP)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .amount(amount),
    .userWe(userWe), .userOff(wrOffset), .userData(wrData),
    .accWe(accGo), .accData(accData), .rdOffset(rdOffset), .fillData(memRspData),
    .spOut(sp), .cntOut(residentCount), .rdData(rdData), .accOut(accOut),
    .spillAddr(spillAddr), .spillData(memReqWdata), .fillAddr(fillAddr)
  );
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int OPC_W = CNT_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opKind,
  input logic [OPC_W-1:0]  opCount,
  input logic              busy,
  input logic [ADDR_W-1:0] sp,
  input logic [CNT_W-1:0]  residentCount,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqWdata
);
  logic [ADDR_W-1:0] freeBytes;
  assign freeBytes = ((opCount > OPC_W'(DEPTH)) ? ADDR_W'(DEPTH) : ADDR_W'(opCount)) << 2;

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)
      && $stable(memReqWrite) && $stable(memReqWdata));

  a_r8_traffic_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    residentCount <= CNT_W'(DEPTH));

  a_r5_spill_drops_one: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady && memReqWrite |=>
      residentCount == $past(residentCount) - CNT_W'(1));

  a_r7_read_then_wait: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady && !memReqWrite |=> busy && !memReqValid);

  a_r6_free_moves_sp: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !busy && opKind == 2'd2 |=> sp == $past(sp) + $past(freeBytes));
endmodule

bind stack_top_cache stc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opCount(opCount),
  .busy(busy), .sp(sp), .residentCount(residentCount), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
  .memReqWdata(memReqWdata)
);

// File: tb/tb_stack_top_cache.sv
module tb_stack_top_cache;
  localparam logic [31:0] RSP = 32'h0000_8000;
  localparam int MW = 16384;

  logic clk = 0, rstN = 0;
  logic opValid = 0; logic [1:0] opKind = 0; logic [7:0] opCount = 0;
  logic busy;
  logic rdEn = 0; logic [5:0] rdOffset = 0; logic [31:0] rdData;
  logic wrEn = 0; logic [5:0] wrOffset = 0; logic [31:0] wrData = 0;
  logic accWe = 0; logic [31:0] accData = 0; logic [31:0] accOut;
  logic accessErr; logic [31:0] sp; logic [6:0] residentCount;
  logic memReqValid, memReqWrite; logic memReqReady = 0;
  logic [31:0] memReqAddr, memReqWdata;
  logic memRspValid = 0; logic [31:0] memRspData = 0;

  int nChecks = 0, nFails = 0;
  logic [31:0] memArr [MW];
  logic [31:0] logical [MW];
  bit known [MW];
  logic [31:0] refSp; int refCnt;
  bit poke = 0;

  always #5 clk = ~clk;

  stack_top_cache #(.RESET_SP(RSP)) dut (.*);

  function automatic int wi(input logic [31:0] a); return int'(a[15:2]); endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin nFails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic serviceMem();
    int guard = 0; bit doRead = 0; logic [31:0] rdA = 0; logic [31:0] expA;
    forever begin
      if (!busy) break;
      opValid = poke; opKind = 2'd2; opCount = 8'd1;
      wrEn = poke; wrOffset = 0; wrData = 32'hDEAD_0000;
      accWe = poke; accData = 32'hDEAD_0001;
      memReqReady = ($urandom % 3) != 0;
      #1;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          expA = refSp + 32'(4 * (refCnt - 1));
          check(memReqAddr == expA, "R5 spill address", memReqAddr, expA);
          if (known[wi(expA)]) check(memReqWdata == logical[wi(expA)], "R5 spill data", memReqWdata, logical[wi(expA)]);
          memArr[wi(expA)] = memReqWdata; logical[wi(expA)] = memReqWdata; known[wi(expA)] = 1;
          refCnt--;
        end else begin
          expA = refSp + 32'(4 * refCnt);
          check(memReqAddr == expA, "R7 fill address", memReqAddr, expA);
          rdA = expA; doRead = 1;
        end
      end
      @(posedge clk); @(negedge clk);
      memReqReady = 0;
      if (doRead) begin
        memRspValid = 1; memRspData = memArr[wi(rdA)];
        @(posedge clk); @(negedge clk);
        memRspValid = 0;
        logical[wi(rdA)] = memArr[wi(rdA)]; known[wi(rdA)] = 1; refCnt++; doRead = 0;
      end
      guard++;
      if (guard > 2000) begin check(0, "R8 busy never fell", 32'(busy), 0); break; end
    end
    opValid = 0; wrEn = 0; accWe = 0;
  endtask

  task automatic doOp(input int kind, input int n);
    int c = (n > 64) ? 64 : n;
    @(negedge clk);
    opValid = 1; opKind = 2'(kind); opCount = 8'(n);
    @(posedge clk); @(negedge clk);
    opValid = 0;
    serviceMem();
    if (kind == 1) begin
      refSp = refSp - 32'(4 * c); refCnt += c;
      for (int k = 0; k < c; k++) known[wi(refSp + 32'(4 * k))] = 0;
      check(sp == refSp, "R4 alloc sp", sp, refSp);
      check(int'(residentCount) == refCnt, "R4 alloc count", 32'(residentCount), 32'(refCnt));
    end else if (kind == 2) begin
      refSp = refSp + 32'(4 * c); refCnt = (c >= refCnt) ? 0 : refCnt - c;
      check(sp == refSp, "R6 free sp", sp, refSp);
      check(int'(residentCount) == refCnt, "R6 free count", 32'(residentCount), 32'(refCnt));
    end else begin
      check(sp == refSp, "R7 restore sp", sp, refSp);
      check(int'(residentCount) == ((refCnt > c) ? refCnt : c), "R7 restore count",
            32'(residentCount), 32'(refCnt));
    end
  endtask

  task automatic checkRead(input int k);
    @(negedge clk);
    rdEn = 1; rdOffset = 6'(k); #1;
    check(accessErr == (k >= refCnt), "R3 read window flag", 32'(accessErr), 32'(k >= refCnt));
    if (k < refCnt && known[wi(refSp + 32'(4 * k))])
      check(rdData == logical[wi(refSp + 32'(4 * k))], "R2 offset read", rdData, logical[wi(refSp + 32'(4 * k))]);
    rdEn = 0;
  endtask

  task automatic writeWord(input int k, input logic [31:0] v);
    @(negedge clk);
    wrEn = 1; wrOffset = 6'(k); wrData = v; #1;
    check(accessErr == (k >= refCnt), "R3 write window flag", 32'(accessErr), 32'(k >= refCnt));
    @(posedge clk); @(negedge clk);
    wrEn = 0;
    if (k < refCnt) begin logical[wi(refSp + 32'(4 * k))] = v; known[wi(refSp + 32'(4 * k))] = 1; end
  endtask

  task automatic accWrite(input logic [31:0] v, input bit alsoWr, input logic [31:0] wv);
    @(negedge clk);
    accWe = 1; accData = v; wrEn = alsoWr; wrOffset = 0; wrData = wv; #1;
    check(accessErr == (refCnt == 0), "R3 accumulator flag", 32'(accessErr), 32'(refCnt == 0));
    @(posedge clk); @(negedge clk);
    accWe = 0; wrEn = 0;
    if (refCnt > 0) begin logical[wi(refSp)] = v; known[wi(refSp)] = 1; end
  endtask

  task automatic checkAcc();
    @(negedge clk);
    if (refCnt > 0 && known[wi(refSp)]) check(accOut == logical[wi(refSp)], "R9 accumulator out", accOut, logical[wi(refSp)]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < MW; i++) begin memArr[i] = $urandom; logical[i] = memArr[i]; known[i] = 1; end
    refSp = RSP; refCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    check(sp == RSP, "R1 reset sp", sp, RSP);
    check(residentCount == 0, "R1 reset count", 32'(residentCount), 0);
    check(!busy && !memReqValid, "R1 reset idle", 32'({busy, memReqValid}), 0);

    // empty window: every access flagged, writes ignored
    checkRead(0);
    writeWord(0, 32'h1111_1111);
    accWrite(32'h2222_2222, 0, 0);
    // restore 4 from empty: fills nearest top first
    doOp(3, 4);
    for (int k = 0; k < 5; k++) checkRead(k);
    checkAcc();
    // fitting alloc shifts offsets
    doOp(1, 10);
    for (int k = 0; k < 10; k++) writeWord(k, 32'hA000_0000 + 32'(k));
    for (int k = 0; k < 15; k++) checkRead(k);
    // R9 priority of accumulator over offset-0 write
    accWrite(32'hACC0_0001, 1, 32'hBAD0_0001);
    checkAcc(); checkRead(0);
    // R5 overflow: alloc 60 on 14 resident, with pokes ignored while busy (R8)
    poke = 1; doOp(1, 60); poke = 0;
    for (int k = 60; k < 64; k++) checkRead(k);
    // R11 clip: alloc 200 acts as 64, spills the full window
    doOp(1, 200);
    checkRead(63);
    for (int k = 0; k < 64; k++) writeWord(k, $urandom);
    // free most, then restore across previously spilled words
    doOp(2, 120);
    poke = 1; doOp(3, 64); poke = 0;
    for (int k = 0; k < 64; k++) checkRead(k);
    // R3 out-of-window write ignored, then refill reveals memory word
    doOp(2, 62);
    writeWord(2, 32'hBAD0_BAD0);
    doOp(3, 3);
    checkRead(2);
    // R7 no traffic when already resident
    doOp(3, 1);

    for (int it = 0; it < 600; it++) begin
      int r = $urandom % 10;
      if (r < 3) writeWord($urandom % 64, $urandom);
      else if (r < 5) checkRead($urandom % 64);
      else if (r == 5 && refSp > 32'h1000) doOp(1, $urandom % 70);
      else if (r == 6 && refSp < 32'hF000) doOp(2, $urandom % 40);
      else if (r == 7) doOp(3, $urandom % 72);
      else if (r == 8) accWrite($urandom, $urandom % 2, $urandom);
      else checkAcc();
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule